// File: doc/BRIEF.md
# Pending-Cell Timeout Scanner

This block decides when a partly filled cell has waited long enough and must be sent without being full. Each of a small, fixed number of channels keeps an expiry time and a valid flag in registers. A free-running time counter advances by one unit of 125 µs each time the tick input pulses. When a packet that starts on or crosses a cell boundary is written to a channel, the producer pulses that channel's boundary input. The block then arms the channel's expiry to the current time plus the channel's timeout period, counted in ticks.

A scanner visits the channels in turn, one per clock cycle. When it finds an armed channel whose expiry has been reached, it issues a single transmission event tagged with the channel number and disarms the channel. The producer disarms a channel when it has nothing pending. A per-channel prevent-scanning input keeps the channel disarmed and silent. The expiry comparison uses the signed difference of two times, so it stays correct when the time counter rolls over.

Top module: `cts_scanner`

## Requirements
- R1: After reset no channel is armed, the time counter reads 0 and `xmit_o` stays low until a channel is armed.
- R2: A boundary pulse on a channel whose prevent-scanning input is low arms it with expiry = current time + period. The counter advances by one for each cycle in which `tick_i` is high. The event comes only after `period` further ticks.
- R3: A period of 0 makes the channel expire at its next scan without any tick.
- R4: A channel that has not been armed never produces an event.
- R5: A no-pending pulse disarms a channel, so that no event follows. If it falls in the cycle in which the scanner finds the channel expired, no event is issued.
- R6: An expiry yields exactly one event and disarms the channel. No repeat follows, whatever the later ticks.
- R7: While prevent-scanning is high the channel is disarmed, boundary pulses do not arm it, and it issues no event. An expiry that was armed before the input rose is lost.
- R8: When a boundary pulse and a detected expiry fall in the same cycle on one channel, the event is issued and the channel is re-armed from the boundary pulse.
- R9: The scanner visits channel indices 0,1,…,NCH-1 and then wraps to 0, one per clock cycle. Channels that expire together report in consecutive cycles, each index one above the previous one, modulo NCH.
- R10: The expiry test is wrap-safe. An expiry that rolls past the counter's maximum value fires only after `period` ticks, not at once.
- R11: `xmit_o` is a one-cycle strobe, registered one cycle after the scan, with `xmit_ch_o` giving the channel index. At most one event is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per 125 µs time unit |
| bnd_i | input | NCH | Per-channel boundary-packet pulse (arm request) |
| idle_i | input | NCH | Per-channel no-packets-pending indication (disarm) |
| hold_i | input | NCH | Per-channel prevent-scanning bit |
| period_i | input | NCH*PW | Per-channel timeout in ticks, channel c in bits [c*PW +: PW] |
| xmit_o | output | 1 | Transmission event strobe |
| xmit_ch_o | output | CHW | Channel index of the event |

## Verification
Two functions can fall in the same cycle: the producer's re-arm of a channel and the scanner's expiry of that channel. The bench learns the scanner's phase from the channel index and cycle of an earlier event. It then holds the boundary input with a zero period across the two edges on which the scanner reaches that channel, so that the scan meets a valid, reached expiry while a re-arm is requested. The result is judged by counting events. Re-arm priority gives two events, one at the collision and one on the next pass. A design that lets the expiry's clear win gives one. A second overlap, a no-pending pulse against a due expiry, is judged by the absence of any event.

// File: rtl/cts_pkg.sv
package cts_pkg;

  // Next-state choice for one channel slot, highest priority first.
  typedef enum logic [2:0] {
    SLOT_BLOCK     = 3'd0,  // prevent-scanning: force disarmed
    SLOT_ARM       = 3'd1,  // boundary packet: load expiry
    SLOT_DROP_IDLE = 3'd2,  // producer has nothing pending
    SLOT_DROP_DUE  = 3'd3,  // scanner consumed the expiry
    SLOT_KEEP      = 3'd4
  } slot_act_e;

endpackage

// File: rtl/cts_timebase.sv
module cts_timebase #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  output logic [TW-1:0] now_o
);

  logic [TW-1:0] now_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      now_q <= '0;
    else if (tick_i) now_q <= now_q + 1'b1;
  end

  assign now_o = now_q;

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> now_q == $past(now_q) + 1'b1);

  // R2
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(now_q));

endmodule

// File: rtl/cts_rr_ptr.sv
module cts_rr_ptr #(
  parameter int NCH = 4,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [CHW-1:0] ptr_o
);

  localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

  logic [CHW-1:0] ptr_q;

  function automatic logic [CHW-1:0] next_index(input logic [CHW-1:0] cur);
    return (cur == LAST) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= next_index(ptr_q);
  end

  assign ptr_o = ptr_q;

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ptr_q) == LAST) ? (ptr_q == '0) : (ptr_q == $past(ptr_q) + 1'b1)));

  // R9
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);

endmodule

// File: rtl/cts_slot.sv
module cts_slot
  import cts_pkg::*;
#(
  parameter int TW = 16,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now_i,
  input  logic          scan_sel_i,
  input  logic          bnd_i,
  input  logic          idle_i,
  input  logic          hold_i,
  input  logic [PW-1:0] period_i,
  output logic          fire_o
);

  logic          valid_q;
  logic [TW-1:0] stamp_q;
  logic          expired;
  logic          scan_due;
  slot_act_e     act;

  // Expiry time = now + period, modulo 2**TW.
  function automatic logic [TW-1:0] arm_value(input logic [TW-1:0] now,
                                              input logic [PW-1:0] per);
    return now + TW'(per);
  endfunction

  // Reached when (now - stamp) is non-negative as a signed TW-bit number.
  function automatic logic reached(input logic [TW-1:0] now,
                                   input logic [TW-1:0] stamp);
    logic [TW-1:0] diff;
    diff = now - stamp;
    return ~diff[TW-1];
  endfunction

  assign expired  = reached(now_i, stamp_q);
  assign scan_due = scan_sel_i & valid_q & expired;
  assign fire_o   = scan_due & ~idle_i & ~hold_i;

  always_comb begin
    if (hold_i)        act = SLOT_BLOCK;
    else if (bnd_i)    act = SLOT_ARM;
    else if (idle_i)   act = SLOT_DROP_IDLE;
    else if (scan_due) act = SLOT_DROP_DUE;
    else               act = SLOT_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      stamp_q <= '0;
    end else begin
      case (act)
        SLOT_ARM: begin
          valid_q <= 1'b1;
          stamp_q <= arm_value(now_i, period_i);
        end
        SLOT_BLOCK, SLOT_DROP_IDLE, SLOT_DROP_DUE: begin
          valid_q <= 1'b0;
          stamp_q <= '0;
        end
        default: ;
      endcase
    end
  end

  // R2
  arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_i && !hold_i) |=> (valid_q && stamp_q == $past(now_i) + TW'($past(period_i))));

  // R7
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !valid_q);

  // R5
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && !bnd_i && !hold_i) |=> !valid_q);

  // R6
  due_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !bnd_i) |=> !valid_q);

  // R8
  due_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && bnd_i) |=> valid_q);

endmodule

// File: rtl/cts_scanner.sv
module cts_scanner #(
  parameter int NCH = 4,
  parameter int TW  = 16,
  parameter int PW  = 10,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [NCH-1:0]    bnd_i,
  input  logic [NCH-1:0]    idle_i,
  input  logic [NCH-1:0]    hold_i,
  input  logic [NCH*PW-1:0] period_i,
  output logic              xmit_o,
  output logic [CHW-1:0]    xmit_ch_o
);

  logic [TW-1:0]  now;
  logic [CHW-1:0] scan_ptr;
  logic [NCH-1:0] fire_vec;
  logic           fire_any;

  cts_timebase #(.TW(TW)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .now_o  (now)
  );

  cts_rr_ptr #(.NCH(NCH), .CHW(CHW)) u_rr_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ptr_o (scan_ptr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    cts_slot #(.TW(TW), .PW(PW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .now_i      (now),
      .scan_sel_i (scan_ptr == CHW'(g)),
      .bnd_i      (bnd_i[g]),
      .idle_i     (idle_i[g]),
      .hold_i     (hold_i[g]),
      .period_i   (period_i[g*PW +: PW]),
      .fire_o     (fire_vec[g])
    );
  end

  assign fire_any = |fire_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xmit_o    <= 1'b0;
      xmit_ch_o <= '0;
    end else begin
      xmit_o    <= fire_any;
      xmit_ch_o <= scan_ptr;
    end
  end

  // R11
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_vec));

  // R11
  strobe_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> xmit_o == $past(fire_any));

  // R11
  strobe_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_o |-> xmit_ch_o == $past(scan_ptr));

endmodule

// File: tb/test_cts_scanner.sv
module test_cts_scanner;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int TW  = 8;
  localparam int PW  = 6;
  localparam int CHW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_i = 1'b0;
  logic [NCH-1:0]    bnd_i = '0;
  logic [NCH-1:0]    idle_i = '0;
  logic [NCH-1:0]    hold_i = '0;
  logic [NCH*PW-1:0] period_i = '0;
  logic              xmit_o;
  logic [CHW-1:0]    xmit_ch_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int now_m = 0;
  int ev_cnt [NCH];
  int log_ch [16];
  int log_cyc [16];
  int log_n = 0;
  int last_ch = 0;
  int last_cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cts_scanner #(.NCH(NCH), .TW(TW), .PW(PW)) i_cts_scanner (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .bnd_i     (bnd_i),
    .idle_i    (idle_i),
    .hold_i    (hold_i),
    .period_i  (period_i),
    .xmit_o    (xmit_o),
    .xmit_ch_o (xmit_ch_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && xmit_o) begin
      ev_cnt[xmit_ch_o]++;
      if (log_n < 16) begin
        log_ch[log_n]  = int'(xmit_ch_o);
        log_cyc[log_n] = cyc;
        log_n++;
      end
      last_ch  = int'(xmit_ch_o);
      last_cyc = cyc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_ev();
    for (int c = 0; c < NCH; c++) ev_cnt[c] = 0;
    log_n = 0;
  endtask

  function automatic int total_ev();
    int s = 0;
    for (int c = 0; c < NCH; c++) s += ev_cnt[c];
    return s;
  endfunction

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_period(input int ch, input int per);
    period_i[ch*PW +: PW] = PW'(per);
  endtask

  task automatic arm(input int ch, input int per);
    @(negedge clk);
    set_period(ch, per);
    bnd_i[ch] = 1'b1;
    @(negedge clk);
    bnd_i[ch] = 1'b0;
  endtask

  task automatic pulse_tick(input int n);
    repeat (n) begin
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      idle_cycles(6);
    end
    now_m = (now_m + n) % 256;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_cycles(3);
    chk("R1 strobe low in reset", int'(xmit_o), 0);
    rst_n = 1'b1;
    clear_ev();
    idle_cycles(10);
    pulse_tick(3);
    chk("R1 no event after reset", total_ev(), 0);
  endtask

  task automatic t_arm_expire();
    clear_ev();
    arm(0, 3);
    idle_cycles(6);
    chk("R2 no event before first tick", ev_cnt[0], 0);
    pulse_tick(2);
    chk("R2 no event before period", ev_cnt[0], 0);
    pulse_tick(1);
    chk("R2 event at period", ev_cnt[0], 1);
    chk("R11 event carries channel 0", last_ch, 0);
    pulse_tick(2);
    chk("R6 single event then disarmed", ev_cnt[0], 1);
    chk("R4 unarmed channels silent", total_ev(), 1);
  endtask

  task automatic t_zero_period();
    clear_ev();
    arm(1, 0);
    idle_cycles(6);
    chk("R3 zero period fires without tick", ev_cnt[1], 1);
    idle_cycles(8);
    chk("R6 zero period fires once", ev_cnt[1], 1);
  endtask

  task automatic t_idle();
    clear_ev();
    arm(2, 2);
    @(negedge clk);
    idle_i[2] = 1'b1;
    @(negedge clk);
    idle_i[2] = 1'b0;
    pulse_tick(3);
    chk("R5 idle disarms channel", ev_cnt[2], 0);
    // due expiry overlapped by idle across a full scan round
    @(negedge clk);
    set_period(2, 0);
    bnd_i[2] = 1'b1;
    @(negedge clk);
    bnd_i[2]  = 1'b0;
    idle_i[2] = 1'b1;
    idle_cycles(5);
    idle_i[2] = 1'b0;
    idle_cycles(8);
    chk("R5 idle suppresses due event", ev_cnt[2], 0);
  endtask

  task automatic t_hold();
    clear_ev();
    @(negedge clk);
    hold_i[3] = 1'b1;
    arm(3, 0);
    idle_cycles(8);
    chk("R7 hold blocks arming", ev_cnt[3], 0);
    hold_i[3] = 1'b0;
    arm(3, 2);
    @(negedge clk);
    hold_i[3] = 1'b1;
    @(negedge clk);
    hold_i[3] = 1'b0;
    pulse_tick(3);
    chk("R7 hold drops pending expiry", ev_cnt[3], 0);
  endtask

  task automatic t_collide();
    int p;
    clear_ev();
    @(negedge clk);
    set_period(3, 0);
    // wait until the coming edge scans channel 2
    for (int k = 0; k < 8; k++) begin
      p = (last_ch - (last_cyc % 4) + ((cyc + 1) % 4) + 8) % 4;
      if (p == 2) break;
      @(negedge clk);
    end
    bnd_i[3] = 1'b1;   // arms on the channel-2 edge
    @(negedge clk);    // channel-3 edge: expiry and re-arm together
    @(negedge clk);
    bnd_i[3] = 1'b0;
    idle_cycles(10);
    chk("R8 collision issues event and re-arms", ev_cnt[3], 2);
  endtask

  task automatic t_round_robin();
    bit order_ok;
    clear_ev();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) set_period(c, 0);
    bnd_i = '1;
    @(negedge clk);
    bnd_i = '0;
    idle_cycles(8);
    chk("R9 all channels report", log_n, NCH);
    order_ok = 1'b1;
    for (int i = 1; i < NCH; i++) begin
      if (log_cyc[i] != log_cyc[i-1] + 1) order_ok = 1'b0;
      if (log_ch[i] != (log_ch[i-1] + 1) % NCH) order_ok = 1'b0;
    end
    chk("R9 consecutive round-robin order", int'(order_ok), 1);
    chk("R11 one event per channel", ev_cnt[0] + ev_cnt[1] * 10 + ev_cnt[2] * 100 + ev_cnt[3] * 1000, 1111);
  endtask

  task automatic t_wrap();
    int n;
    clear_ev();
    n = (250 - now_m + 256) % 256;
    if (n > 0) begin
      repeat (n) begin
        @(negedge clk);
        tick_i = 1'b1;
      end
      @(negedge clk);
      tick_i = 1'b0;
      now_m = (now_m + n) % 256;
    end
    idle_cycles(6);
    arm(0, 10);
    idle_cycles(6);
    chk("R10 no immediate fire across rollover", ev_cnt[0], 0);
    pulse_tick(9);
    chk("R10 no fire before period across rollover", ev_cnt[0], 0);
    pulse_tick(1);
    chk("R10 fires after period across rollover", ev_cnt[0], 1);
  endtask

  initial begin
    t_reset();
    t_arm_expire();
    t_zero_period();
    t_idle();
    t_hold();
    t_collide();
    t_round_robin();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule